// File: doc/BRIEF.md
# Predicated Vector Element Add Sequencer

This block runs one add instruction over a run of register-file elements, handling one element per clock cycle. The destination and both sources each carry a tag that says whether the operand is a vector or a scalar. A vector operand starts at a base register index that has already been remapped, and its offset grows by one after every element. A scalar operand keeps its own register number for the whole run. A predicate mask decides which elements are written. The register file sits outside the block. The block drives two combinational read addresses and one synchronous write port toward it.

The instruction is started with a one-cycle `start` pulse. The block samples the vector length, the predicate mask and the three operand descriptors on that edge. It keeps `busy` high while elements are being stepped and raises `done` for one cycle at the end. The index of the element being processed is shown on `src_offs` as saved loop state, so a trap handler could resume the loop. This index returns to zero when the loop finishes. The operand tags select one of several modes:

- Vector with vector.
- Vector with a scalar broadcast.
- Splat: a vector destination fed by two scalars.
- Scalar destination: the write stops after the first enabled element.

Top module: `vec_add_seq`

## Requirements
- R1: A start pulse with a length VL of 1 or more sets busy in the following cycle. Busy stays high for exactly as many cycles as elements are stepped. Done is then high for exactly one cycle, and busy is low during that cycle.
- R2: A start pulse with VL equal to 0 writes nothing. Done rises in the cycle after start, and busy stays low.
- R3: Element i (counted from 0) is written only when bit i of the predicate mask is 1. No write happens while the block is idle.
- R4: The register address of an operand is computed as follows. For a vector operand it is the base index plus the element offset, modulo 32. For a scalar operand it is the operand's own register number, and the base input is ignored.
- R5: With all three operands vector, element i writes `reg[ra_base+i] + reg[rb_base+i]` to `reg[rt_base+i]`. Reads see the writes of earlier elements of the same run.
- R6: When exactly one source is vector and the other is scalar, every enabled element adds its vector source element to the same scalar register.
- R7: With a scalar destination, only the first enabled element is written, and done follows in the next cycle. If no element is enabled, all VL elements are stepped and nothing is written.
- R8: With a vector destination and two scalar sources, every enabled destination element receives the same sum.
- R9: While element i is being processed, `src_offs` equals i. In every cycle where busy is low, it is 0.
- R10: A start pulse that arrives while busy is high is ignored. It has no effect on any write or on the timing of done.
- R11: The sum is the 64-bit result taken modulo 2^64. A carry out of bit 63 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin an instruction |
| vl | input | 7 | Vector length, 0 to 64 |
| pred | input | 64 | Predicate mask, bit i enables element i |
| rt_vec | input | 1 | Destination is a vector |
| rt_num | input | 5 | Destination register number (scalar use) |
| rt_base | input | 5 | Destination remapped base index (vector use) |
| ra_vec | input | 1 | First source is a vector |
| ra_num | input | 5 | First source register number |
| ra_base | input | 5 | First source remapped base index |
| rb_vec | input | 1 | Second source is a vector |
| rb_num | input | 5 | Second source register number |
| rb_base | input | 5 | Second source remapped base index |
| busy | output | 1 | Loop is running |
| done | output | 1 | One-cycle completion pulse |
| src_offs | output | 7 | Saved element index |
| rf_a_addr | output | 5 | Read address, first source |
| rf_a_data | input | 64 | Read data, first source (combinational) |
| rf_b_addr | output | 5 | Read address, second source |
| rf_b_data | input | 64 | Read data, second source (combinational) |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write address |
| rf_wdata | output | 64 | Register write data |

## Verification
The bench targets several corner cases, each of which exposes a specific wrong design:

- **Scalar-destination early stop.** A design that ignores the stop would keep overwriting the same register with later sums. A design that stops on the first element, enabled or not, would skip the wanted write.
- **Splat mode.** A design that steps the scalar sources would add the wrong registers.
- **Zero length.** A design that enters the loop when VL is 0 would issue a stray write or delay done.
- **Address wrap past register 31.** A design without the modulo would index out of range.
- **Carry out of bit 63.** A design without the modulo would return a wrong sum.
- **Read-after-write within a run.** A design that captured the source values up front would return stale sums.
- **Full 64-element run.** A wrong counter width would cut the run short.
- **Start pulse mid-run.** A design that accepted it would restart the run and shift the write stream.

// File: rtl/vas_pkg.sv
package vas_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } vas_state_e;

    // operand slots of the stepper array
    localparam int OP_DST  = 0;
    localparam int OP_SRCA = 1;
    localparam int OP_SRCB = 2;
    localparam int NUM_OPS = 3;

endpackage

// File: rtl/vas_opnd.sv
// One operand stepper: latches the start register, walks the element offset
// for vector operands and flags the final step.
module vas_opnd #(
    parameter int AW  = 5,
    parameter int VLW = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic           is_vec,
    input  logic [AW-1:0]  num,
    input  logic [AW-1:0]  base,
    input  logic [VLW-1:0] run_len,
    output logic [AW-1:0]  addr,
    output logic           at_end
);

    typedef struct packed {
        logic           vec;
        logic [AW-1:0]  start_reg;
        logic [VLW-1:0] offs;
    } opnd_t;

    opnd_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.vec       = is_vec;
            st_d.start_reg = is_vec ? base : num;
            st_d.offs      = '0;
        end else if (step && st_q.vec) begin
            st_d.offs = st_q.offs + VLW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // register index wraps modulo the file size
    assign addr   = st_q.start_reg + AW'(st_q.offs);
    assign at_end = st_q.vec && ((st_q.offs + VLW'(1)) == run_len);

endmodule

// File: rtl/vas_ctrl.sv
// Loop sequencer: start acceptance, element index, predicate shifting,
// termination and the completion pulse.
module vas_ctrl
    import vas_pkg::*;
#(
    parameter int MAXVL = 64,
    parameter int VLW   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VLW-1:0]   vl_in,
    input  logic [MAXVL-1:0] pred_in,
    input  logic             dst_vec_in,
    input  logic             any_end,
    output logic             load,
    output logic             step,
    output logic             wr_en,
    output logic             busy,
    output logic             done,
    output logic [VLW-1:0]   src_offs,
    output logic [VLW-1:0]   run_len
);

    typedef struct packed {
        vas_state_e       st;
        logic [VLW-1:0]   idx;
        logic [VLW-1:0]   len;
        logic [MAXVL-1:0] pmask;
        logic             dvec;
        logic             done;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  last_elem;

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        load      = 1'b0;
        step      = 1'b0;
        wr_en     = 1'b0;
        last_elem = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    if (vl_in == '0) begin
                        c_d.done = 1'b1;
                    end else begin
                        c_d.st    = ST_RUN;
                        c_d.idx   = '0;
                        c_d.len   = vl_in;
                        c_d.pmask = pred_in;
                        c_d.dvec  = dst_vec_in;
                    end
                end
            end
            ST_RUN: begin
                wr_en     = c_q.pmask[0];
                step      = 1'b1;
                last_elem = ((c_q.idx + VLW'(1)) == c_q.len) || any_end
                            || (!c_q.dvec && c_q.pmask[0]);
                if (last_elem) begin
                    c_d.st   = ST_IDLE;
                    c_d.idx  = '0;
                    c_d.done = 1'b1;
                end else begin
                    c_d.idx   = c_q.idx + VLW'(1);
                    c_d.pmask = c_q.pmask >> 1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy     = (c_q.st == ST_RUN);
    assign done     = c_q.done;
    assign src_offs = c_q.idx;
    assign run_len  = c_q.len;

endmodule

// File: rtl/vec_add_seq.sv
module vec_add_seq
    import vas_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int XLEN  = 64,
    parameter int MAXVL = 64,
    localparam int AW   = $clog2(NREG),
    localparam int VLW  = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VLW-1:0]   vl,
    input  logic [MAXVL-1:0] pred,
    input  logic             rt_vec,
    input  logic [AW-1:0]    rt_num,
    input  logic [AW-1:0]    rt_base,
    input  logic             ra_vec,
    input  logic [AW-1:0]    ra_num,
    input  logic [AW-1:0]    ra_base,
    input  logic             rb_vec,
    input  logic [AW-1:0]    rb_num,
    input  logic [AW-1:0]    rb_base,
    output logic             busy,
    output logic             done,
    output logic [VLW-1:0]   src_offs,
    output logic [AW-1:0]    rf_a_addr,
    input  logic [XLEN-1:0]  rf_a_data,
    output logic [AW-1:0]    rf_b_addr,
    input  logic [XLEN-1:0]  rf_b_data,
    output logic             rf_we,
    output logic [AW-1:0]    rf_waddr,
    output logic [XLEN-1:0]  rf_wdata
);

    logic [NUM_OPS-1:0] op_vec;
    logic [AW-1:0]      op_num  [NUM_OPS];
    logic [AW-1:0]      op_base [NUM_OPS];
    logic [AW-1:0]      op_addr [NUM_OPS];
    logic [NUM_OPS-1:0] op_end;
    logic               ld, stp, wen;
    logic [VLW-1:0]     run_len;

    assign op_vec = {rb_vec, ra_vec, rt_vec};
    assign op_num[OP_DST]   = rt_num;
    assign op_num[OP_SRCA]  = ra_num;
    assign op_num[OP_SRCB]  = rb_num;
    assign op_base[OP_DST]  = rt_base;
    assign op_base[OP_SRCA] = ra_base;
    assign op_base[OP_SRCB] = rb_base;

    vas_ctrl #(
        .MAXVL (MAXVL),
        .VLW   (VLW)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .vl_in      (vl),
        .pred_in    (pred),
        .dst_vec_in (rt_vec),
        .any_end    (|op_end),
        .load       (ld),
        .step       (stp),
        .wr_en      (wen),
        .busy       (busy),
        .done       (done),
        .src_offs   (src_offs),
        .run_len    (run_len)
    );

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_opnd
        vas_opnd #(
            .AW  (AW),
            .VLW (VLW)
        ) u_opnd (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (ld),
            .step    (stp),
            .is_vec  (op_vec[g]),
            .num     (op_num[g]),
            .base    (op_base[g]),
            .run_len (run_len),
            .addr    (op_addr[g]),
            .at_end  (op_end[g])
        );
    end

    assign rf_a_addr = op_addr[OP_SRCA];
    assign rf_b_addr = op_addr[OP_SRCB];
    assign rf_waddr  = op_addr[OP_DST];
    assign rf_we     = wen;
    assign rf_wdata  = rf_a_data + rf_b_data;

endmodule

// File: rtl/vas_chk.sv
module vas_chk #(
    parameter int VLW = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [VLW-1:0] vl,
    input logic           busy,
    input logic           done,
    input logic [VLW-1:0] src_offs,
    input logic           rf_we
);

    // R1
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R1
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R2
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (vl == '0)) |=> (done && !busy));

    // R3
    write_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> busy);

    // R9
    offs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (src_offs == '0));

    // R9
    offs_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (src_offs == '0));

    // R10
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

bind vec_add_seq vas_chk #(.VLW(VLW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .vl       (vl),
    .busy     (busy),
    .done     (done),
    .src_offs (src_offs),
    .rf_we    (rf_we)
);

// File: tb/sim_vec_add_seq.sv
`timescale 1ns/1ps
module sim_vec_add_seq;

    localparam int NREG  = 32;
    localparam int XLEN  = 64;
    localparam int MAXVL = 64;
    localparam int AW    = 5;
    localparam int VLW   = 7;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n;
    logic             start;
    logic [VLW-1:0]   vl;
    logic [MAXVL-1:0] pred;
    logic             rt_vec, ra_vec, rb_vec;
    logic [AW-1:0]    rt_num, rt_base, ra_num, ra_base, rb_num, rb_base;
    logic             busy, done, rf_we;
    logic [VLW-1:0]   src_offs;
    logic [AW-1:0]    rf_a_addr, rf_b_addr, rf_waddr;
    logic [XLEN-1:0]  rf_a_data, rf_b_data, rf_wdata;

    logic [XLEN-1:0]  mem [NREG];
    logic [XLEN-1:0]  mdl [NREG];
    logic             pl_we;
    logic [AW-1:0]    pl_addr;
    logic [XLEN-1:0]  pl_data;

    typedef struct {
        logic [AW-1:0]   a;
        logic [XLEN-1:0] d;
        string           tag;
    } exp_t;
    exp_t sbq [$];

    int checks = 0;
    int errors = 0;

    vec_add_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .pred(pred),
        .rt_vec(rt_vec), .rt_num(rt_num), .rt_base(rt_base),
        .ra_vec(ra_vec), .ra_num(ra_num), .ra_base(ra_base),
        .rb_vec(rb_vec), .rb_num(rb_num), .rb_base(rb_base),
        .busy(busy), .done(done), .src_offs(src_offs),
        .rf_a_addr(rf_a_addr), .rf_a_data(rf_a_data),
        .rf_b_addr(rf_b_addr), .rf_b_data(rf_b_data),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    // environment register file
    assign rf_a_data = mem[rf_a_addr];
    assign rf_b_data = mem[rf_b_addr];
    always @(posedge clk) begin
        if (rf_we) mem[rf_waddr] <= rf_wdata;
        else if (pl_we) mem[pl_addr] <= pl_data;
    end

    // monitor: compare every write against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rf_we) begin
            checks++;
            if (sbq.size() == 0) begin
                errors++;
                $display("FAIL R3 unexpected write addr %0d data %h, expected no write",
                         rf_waddr, rf_wdata);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (e.a !== rf_waddr || e.d !== rf_wdata) begin
                    errors++;
                    $display("FAIL %s write addr %0d data %h, expected addr %0d data %h",
                             e.tag, rf_waddr, rf_wdata, e.a, e.d);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic preload(input int a, input logic [XLEN-1:0] d);
        @(negedge clk);
        pl_we = 1'b1; pl_addr = AW'(a); pl_data = d;
        @(negedge clk);
        pl_we = 1'b0;
        mdl[a] = d;
    endtask

    task automatic run_op(input string tag, input int len, input logic [MAXVL-1:0] pm,
                          input bit tv, input int tn, input int tb,
                          input bit av, input int an, input int ab,
                          input bit bv, input int bn, input int bb,
                          input bit poke);
        int k;
        int n;
        k = len;
        // expected writes from the requirements
        for (int i = 0; i < len; i++) begin
            logic [AW-1:0] ta, aa, ba;
            ta = tv ? AW'(tb + i) : AW'(tn);
            aa = av ? AW'(ab + i) : AW'(an);
            ba = bv ? AW'(bb + i) : AW'(bn);
            if (pm[i]) begin
                exp_t e;
                e.a = ta; e.d = mdl[aa] + mdl[ba]; e.tag = tag;
                sbq.push_back(e);
                mdl[ta] = e.d;
                if (!tv) begin
                    k = i + 1;
                    break;
                end
            end
        end
        @(negedge clk);
        vl = VLW'(len); pred = pm;
        rt_vec = tv; rt_num = AW'(tn); rt_base = AW'(tb);
        ra_vec = av; ra_num = AW'(an); ra_base = AW'(ab);
        rb_vec = bv; rb_num = AW'(bn); rb_base = AW'(bb);
        start = 1'b1;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1) start = 1'b0;
            if (poke && n == 2) begin
                // R10 stray start with a different instruction
                start = 1'b1; vl = 7'd0; pred = '1; rt_vec = 1'b0; rt_num = 5'd0;
            end
            if (poke && n == 3) start = 1'b0;
            if (n == 1 && len > 0) chk({tag, " R1 busy after start"}, 64'(busy), 64'd1);
            if (!done && n <= k) chk({tag, " R9 src_offs"}, 64'(src_offs), 64'(n - 1));
            if (done) begin
                chk({tag, " R1 done cycle"}, 64'(n), 64'(k + 1));
                chk({tag, " R9 src_offs at done"}, 64'(src_offs), 64'd0);
                break;
            end
            if (n > 300) begin
                errors++;
                $display("FAIL %s R1 no done after %0d cycles, expected %0d", tag, n, k + 1);
                break;
            end
        end
        @(negedge clk);
        chk({tag, " R1 done single"}, 64'(done), 64'd0);
        chk({tag, " R1 busy low after"}, 64'(busy), 64'd0);
        chk({tag, " R3 pending writes"}, 64'(sbq.size()), 64'd0);
        sbq.delete();
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; vl = '0; pred = '0;
        rt_vec = 0; rt_num = 0; rt_base = 0;
        ra_vec = 0; ra_num = 0; ra_base = 0;
        rb_vec = 0; rb_num = 0; rb_base = 0;
        pl_we = 1'b0; pl_addr = '0; pl_data = '0;
        repeat (3) @(negedge clk);
        // reset state R1 R9
        chk("R1 reset busy", 64'(busy), 64'd0);
        chk("R1 reset done", 64'(done), 64'd0);
        chk("R9 reset src_offs", 64'(src_offs), 64'd0);
        chk("R3 reset we", 64'(rf_we), 64'd0);
        rst_n = 1'b1;
        for (int j = 0; j < NREG; j++)
            preload(j, 64'h0101_0000_0000_0000 * 64'(j) + 64'(j * 7 + 3));

        // R5 R4 vector with vector
        run_op("R5", 4, '1, 1, 3, 8, 1, 9, 0, 1, 4, 16, 0);
        // R3 predicated vector
        run_op("R3", 6, 64'b101001, 1, 0, 20, 1, 0, 2, 1, 0, 12, 0);
        // R6 vector plus scalar, then scalar plus vector
        run_op("R6", 5, '1, 1, 0, 20, 1, 0, 2, 0, 31, 7, 0);
        run_op("R6", 5, 64'b10111, 1, 0, 1, 0, 30, 9, 1, 0, 14, 0);
        // R8 splat
        run_op("R8", 6, 64'b110110, 1, 0, 24, 0, 1, 19, 0, 2, 23, 0);
        // R7 scalar destination, first enabled is element 3
        run_op("R7", 8, 64'b11111000, 0, 7, 17, 1, 0, 10, 1, 0, 12, 0);
        // R7 scalar destination, nothing enabled
        run_op("R7", 3, '0, 0, 7, 0, 1, 0, 10, 1, 0, 12, 0);
        // R7 all scalar
        run_op("R7", 5, '1, 0, 6, 11, 0, 4, 13, 0, 5, 15, 0);
        // R2 zero length
        run_op("R2", 0, '1, 1, 0, 0, 1, 0, 0, 1, 0, 0, 0);
        // R11 carry out of bit 63
        preload(3, 64'hFFFF_FFFF_FFFF_FFFF);
        preload(4, 64'd5);
        run_op("R11", 1, '1, 0, 9, 0, 0, 3, 0, 0, 4, 0, 0);
        // R4 address wrap past 31
        run_op("R4", 4, '1, 1, 0, 30, 1, 0, 28, 0, 0, 3, 0);
        // R5 read after write inside one run
        run_op("R5", 4, '1, 1, 0, 11, 1, 0, 10, 0, 1, 0, 0);
        // R10 start while busy
        run_op("R10", 5, 64'b11011, 1, 0, 14, 1, 0, 5, 1, 0, 22, 1);
        // R3 full length run
        run_op("R3", 64, 64'hAAAA_5555_F0F0_0F0F, 1, 0, 0, 1, 0, 0, 0, 31, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule